// File: doc/BRIEF.md
# ADC Handshake Sequencer

This block drives the control pins of an external 8-bit successive-approximation converter whose chip select is permanently tied active. Its three control signals are all active low: a start strobe (the converter samples on its rising edge), a read strobe (the converter drives its result onto a shared data bus only while this strobe is low), and an end-of-conversion flag raised by the converter when the result is ready.

A single start request runs one full transaction. First the start strobe goes low for a programmable width. Then the sequencer polls the synchronised end-of-conversion flag, and then drives the read strobe low for a programmable width. It captures the bus on the last read cycle and presents the byte with a one-cycle valid pulse. Between transactions both strobes stay high, so the converter leaves the shared bus undriven. If the flag never arrives, a timeout releases everything and raises a one-cycle error pulse.

Top module: `adc_hs_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, wr_n_o and rd_n_o are 1 and busy_o, sample_vld_o, timeout_o are 0; sample_o resets to 0.
- R2: A start_i sampled high while idle drives wr_n_o low for exactly WR_LOW_CYC consecutive cycles (rd_n_o stays 1), and busy_o is 1 in every one of those cycles.
- R3: Whenever busy_o is 0, both strobes are 1; after wr_n_o returns high, both strobes stay 1 while end-of-conversion is awaited.
- R4: rd_n_o is low for exactly RD_LOW_CYC consecutive cycles per conversion, and wr_n_o and rd_n_o are never low in the same cycle.
- R5: sample_o takes the value on bus_i during the last read-low cycle and holds it unchanged until the next successful capture.
- R6: sample_vld_o is 1 for exactly one cycle per successful conversion, in the first cycle after rd_n_o returns high, with busy_o already 0.
- R7: start_i is ignored while busy_o is 1: a held or repeated request produces no extra write strobe.
- R8: If the synchronised end-of-conversion is not low within TIMEOUT_CYC waiting cycles, timeout_o pulses for one cycle, both strobes are 1, busy_o is 0 and no sample_vld_o is given.
- R9: eoc_n_i passes through a SYNC_STAGES flop synchroniser: when eoc_n_i falls just after a clock edge, rd_n_o is first low SYNC_STAGES+1 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion (sampled while idle) |
| eoc_n_i | input | 1 | Converter end-of-conversion flag, active low, asynchronous |
| bus_i | input | DATA_W | Shared data bus from the converter |
| wr_n_o | output | 1 | Start strobe to the converter, active low |
| rd_n_o | output | 1 | Read strobe to the converter, active low |
| busy_o | output | 1 | Transaction in progress, from write-low until read release |
| sample_o | output | DATA_W | Last captured result |
| sample_vld_o | output | 1 | One-cycle pulse when sample_o is updated |
| timeout_o | output | 1 | One-cycle pulse when the wait for end-of-conversion expired |

## Verification
The bound checker watches, on every cycle, the relations that hold locally: strobes never low together, strobes high whenever idle, a write strobe starting only from idle, single-cycle valid and error pulses with busy already clear, and the sample staying put outside a capture. Exact pulse widths, the synchroniser latency from the end-of-conversion edge to the read strobe, the exact timeout window and the captured byte against the value the converter model presented can only be shown by the bench scenarios, which measure them at the ports.

// File: rtl/adc_hs_pkg.sv
package adc_hs_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WR   = 2'd1,
        SEQ_WAIT = 2'd2,
        SEQ_RD   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/adc_hs_sync.sv
module adc_hs_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/adc_hs_timer.sv
module adc_hs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)     cnt_d = '0;
        else if (en_i) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/adc_hs_seq.sv
module adc_hs_seq
    import adc_hs_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int WR_LOW_CYC  = 3,
    parameter int RD_LOW_CYC  = 2,
    parameter int TIMEOUT_CYC = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              eoc_n_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic              wr_n_o,
    output logic              rd_n_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] sample_o,
    output logic              sample_vld_o,
    output logic              timeout_o
);

    localparam int MAX_PH  = (WR_LOW_CYC > RD_LOW_CYC) ? WR_LOW_CYC : RD_LOW_CYC;
    localparam int MAX_LIM = (TIMEOUT_CYC > MAX_PH) ? TIMEOUT_CYC : MAX_PH;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);
    localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_LOW_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_LOW_CYC - 1);
    localparam logic [CNT_W-1:0] TO_LAST = CNT_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [DATA_W-1:0] sample;
        logic              vld;
        logic              err;
    } seq_regs_t;

    seq_regs_t        r_d, r_q;
    logic             eoc_n_s;
    logic             tmr_clr;
    logic [CNT_W-1:0] tmr_cnt;
    logic             in_txn;

    adc_hs_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) eoc_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (eoc_n_i),
        .sync_o  (eoc_n_s)
    );

    assign in_txn = (r_q.state != SEQ_IDLE);

    adc_hs_timer #(
        .W (CNT_W)
    ) phase_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .en_i  (in_txn),
        .cnt_o (tmr_cnt)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        r_d.err = 1'b0;
        tmr_clr = 1'b0;
        unique case (r_q.state)
            SEQ_IDLE: begin
                if (start_i) begin
                    r_d.state = SEQ_WR;
                    tmr_clr   = 1'b1;
                end
            end
            SEQ_WR: begin
                if (tmr_cnt == WR_LAST) begin
                    r_d.state = SEQ_WAIT;
                    tmr_clr   = 1'b1;
                end
            end
            SEQ_WAIT: begin
                if (!eoc_n_s) begin
                    r_d.state = SEQ_RD;
                    tmr_clr   = 1'b1;
                end else if (tmr_cnt == TO_LAST) begin
                    r_d.state = SEQ_IDLE;
                    r_d.err   = 1'b1;
                    tmr_clr   = 1'b1;
                end
            end
            SEQ_RD: begin
                if (tmr_cnt == RD_LAST) begin
                    r_d.state  = SEQ_IDLE;
                    r_d.sample = bus_i;
                    r_d.vld    = 1'b1;
                    tmr_clr    = 1'b1;
                end
            end
            default: r_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= SEQ_IDLE;
            r_q.sample <= '0;
            r_q.vld    <= 1'b0;
            r_q.err    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_n_o       = (r_q.state != SEQ_WR);
    assign rd_n_o       = (r_q.state != SEQ_RD);
    assign busy_o       = in_txn;
    assign sample_o     = r_q.sample;
    assign sample_vld_o = r_q.vld;
    assign timeout_o    = r_q.err;

endmodule

// File: rtl/adc_hs_seq_chk.sv
module adc_hs_seq_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_n_o,
    input logic              rd_n_o,
    input logic              busy_o,
    input logic [DATA_W-1:0] sample_o,
    input logic              sample_vld_o,
    input logic              timeout_o
);

    p_wr_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> busy_o);

    p_idle_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (wr_n_o && rd_n_o));

    p_rd_after_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n_o) |-> $past(busy_o && wr_n_o));

    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> rd_n_o);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld_o |-> $stable(sample_o));

    p_vld_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld_o |=> !sample_vld_o);

    p_vld_after_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld_o |-> (!busy_o && $past(!rd_n_o)));

    p_wr_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n_o) |-> $past(!busy_o));

    p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (!busy_o && !sample_vld_o && $past(busy_o && wr_n_o && rd_n_o)));

    p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);

endmodule

bind adc_hs_seq adc_hs_seq_chk #(
    .DATA_W (DATA_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_n_o       (wr_n_o),
    .rd_n_o       (rd_n_o),
    .busy_o       (busy_o),
    .sample_o     (sample_o),
    .sample_vld_o (sample_vld_o),
    .timeout_o    (timeout_o)
);

// File: tb/adc_hs_seq_tb_top.sv
`timescale 1ns/1ps
module adc_hs_seq_tb_top;

    localparam int DW  = 8;
    localparam int WRC = 3;
    localparam int RDC = 2;
    localparam int TOC = 40;
    localparam int SYN = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          eoc_n = 1'b1;
    logic [DW-1:0] adc_val = '0;
    logic [DW-1:0] bus;
    logic          wr_n, rd_n, busy, vld, tmo;
    logic [DW-1:0] sample;

    always #2.5 clk = ~clk;

    // converter bus: driven only while read strobe is low, pulled high otherwise
    assign bus = rd_n ? '1 : adc_val;

    adc_hs_seq #(
        .DATA_W      (DW),
        .WR_LOW_CYC  (WRC),
        .RD_LOW_CYC  (RDC),
        .TIMEOUT_CYC (TOC),
        .SYNC_STAGES (SYN)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .eoc_n_i      (eoc_n),
        .bus_i        (bus),
        .wr_n_o       (wr_n),
        .rd_n_o       (rd_n),
        .busy_o       (busy),
        .sample_o     (sample),
        .sample_vld_o (vld),
        .timeout_o    (tmo)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // monitor and converter model state
    int conv_delay = -1;
    int conv_cnt = 0;
    bit conv_act = 0;
    bit wr_prev = 1;
    int wr_run = 0, rd_run = 0, wait_run = 0;
    int last_wr_w = 0, last_rd_w = 0, last_wait = 0;
    int wr_pulses = 0, vld_cnt = 0, err_cnt = 0;
    int eoc_age = 0, last_rd_lat = 0;
    int both_low = 0, wr_not_busy = 0, vld_busy = 0, err_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (!eoc_n) eoc_age++;
            if (!wr_n) begin
                if (wr_run == 0) wr_pulses++;
                wr_run++;
                if (!busy) wr_not_busy++;
            end else if (wr_run != 0) begin
                last_wr_w = wr_run;
                wr_run = 0;
            end
            if (!rd_n) begin
                if (rd_run == 0) last_rd_lat = eoc_age;
                rd_run++;
            end else if (rd_run != 0) begin
                last_rd_w = rd_run;
                rd_run = 0;
            end
            if (!wr_n && !rd_n) both_low++;
            if (busy && wr_n && rd_n) wait_run++;
            else if (wait_run != 0) begin
                last_wait = wait_run;
                wait_run = 0;
            end
            if (vld) begin
                vld_cnt++;
                if (busy) vld_busy++;
            end
            if (tmo) begin
                err_cnt++;
                if (busy || !wr_n || !rd_n) err_bad++;
            end
            // converter model
            if (!rd_n) eoc_n = 1'b1;
            if (!wr_prev && wr_n && conv_delay >= 0) begin
                conv_act = 1;
                conv_cnt = conv_delay;
            end
            if (conv_act) begin
                if (conv_cnt == 0) begin
                    eoc_n = 1'b0;
                    eoc_age = 0;
                    conv_act = 0;
                end else conv_cnt--;
            end
            wr_prev = wr_n;
        end
    end

    task automatic pulse_start();
        @(negedge clk); #1;
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 600; i++) begin
            @(negedge clk); #1;
            if (vld || tmo) break;
        end
    endtask

    task automatic t_reset();
        #1;
        chk(wr_n == 1'b1 && rd_n == 1'b1, "R1", "strobes in reset", {wr_n, rd_n}, 3);
        chk(!busy && !vld && !tmo, "R1", "flags in reset", {busy, vld, tmo}, 0);
        @(negedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(wr_n && rd_n && !busy, "R1", "state after reset", {wr_n, rd_n, busy}, 6);
        chk(sample == '0 && !vld && !tmo, "R1", "sample after reset", int'(sample), 0);
    endtask

    task automatic t_conv(input logic [DW-1:0] val, input int delay);
        int p0, v0, e0;
        p0 = wr_pulses; v0 = vld_cnt; e0 = err_cnt;
        adc_val = val;
        conv_delay = delay;
        pulse_start();
        wait_done();
        chk(last_wr_w == WRC, "R2", "write low width", last_wr_w, WRC);
        chk(wr_not_busy == 0, "R2", "busy during write", wr_not_busy, 0);
        chk(last_rd_w == RDC, "R4", "read low width", last_rd_w, RDC);
        chk(last_rd_lat == SYN + 1, "R9", "eoc to read latency", last_rd_lat, SYN + 1);
        chk(sample == val, "R5", "captured sample", int'(sample), int'(val));
        chk(vld && !busy, "R6", "valid with busy clear", {vld, busy}, 2);
        chk(vld_cnt - v0 == 1, "R6", "valid count", vld_cnt - v0, 1);
        chk(err_cnt == e0, "R8", "no timeout", err_cnt - e0, 0);
        chk(wr_pulses - p0 == 1, "R2", "write pulses", wr_pulses - p0, 1);
        @(negedge clk); #1;
        chk(!vld, "R6", "valid one cycle", int'(vld), 0);
        adc_val = ~val;
        repeat (4) @(negedge clk);
        #1;
        chk(sample == val && wr_n && rd_n && !busy, "R5", "sample held while idle",
            int'(sample), int'(val));
    endtask

    task automatic t_start_busy();
        int p0, v0;
        p0 = wr_pulses; v0 = vld_cnt;
        adc_val = 8'h3C;
        conv_delay = 8;
        @(negedge clk); #1;
        start = 1'b1;
        repeat (10) @(negedge clk);
        #1;
        chk(busy, "R7", "still busy with start held", int'(busy), 1);
        start = 1'b0;
        @(negedge clk); #1;
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        wait_done();
        repeat (3) @(negedge clk);
        #1;
        chk(wr_pulses - p0 == 1, "R7", "extra write strobes", wr_pulses - p0, 1);
        chk(vld_cnt - v0 == 1, "R7", "conversions done", vld_cnt - v0, 1);
        chk(sample == 8'h3C, "R7", "sample of single run", int'(sample), 8'h3C);
    endtask

    task automatic t_timeout();
        int v0, e0;
        logic [DW-1:0] prev;
        v0 = vld_cnt; e0 = err_cnt; prev = sample;
        conv_delay = -1;
        pulse_start();
        wait_done();
        chk(tmo && !busy && wr_n && rd_n, "R8", "timeout state", {tmo, busy, wr_n, rd_n}, 11);
        chk(last_wait == TOC, "R8", "wait cycles before timeout", last_wait, TOC);
        chk(vld_cnt == v0, "R8", "no valid on timeout", vld_cnt - v0, 0);
        @(negedge clk); #1;
        chk(!tmo && err_cnt - e0 == 1, "R8", "timeout pulses", err_cnt - e0, 1);
        chk(sample == prev, "R5", "sample kept on timeout", int'(sample), int'(prev));
        chk(err_bad == 0, "R8", "strobes released on timeout", err_bad, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        t_reset();
        t_conv(8'hA5, 0);
        t_conv(8'h00, 5);
        t_conv(8'hFF, 12);
        t_conv(8'h5A, 2);
        t_start_busy();
        t_timeout();
        t_conv(8'h81, 3);
        chk(both_low == 0, "R4", "cycles with both strobes low", both_low, 0);
        chk(vld_busy == 0, "R6", "valid while busy", vld_busy, 0);
        chk(wr_not_busy == 0, "R3", "write strobe outside busy", wr_not_busy, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule